// File: doc/BRIEF.md
# Johnson Decade Counter with One-Hot Decoder

This block divides its clock by ten. The count lives in a five-bit twisted-ring (Johnson) shift register. Ten decoded lines show the count one-hot: line k is high while the counter is in state k. A carry line runs at one tenth of the clock rate with a 50% duty cycle. It rises as the count wraps from 9 to 0, so the carry can drive the clock of a following counter when several stages are chained.

An active-high hold input stops counting and keeps the present state. An active-high clear input forces the counter to state 0 at once, without waiting for a clock edge, and it wins over both hold and the clock. Twenty-two of the thirty-two register patterns are not part of the ten-state ring. If the register ever holds one of them, the next counted edge sends the counter straight to state 0, so the counter cannot get stuck in a false loop.

Top module: `johnson_decade`

## Requirements
- R1: While clr is high, sel equals 10'b00_0000_0001 and carry is 1. This takes effect at once, with no clock edge needed.
- R2: On each rising clk edge with hold low and clr low, the state advances from k to (k+1) mod 10. sel[k] marks state k, so the high line moves up one place and wraps from sel[9] to sel[0].
- R3: In any legal state, exactly one bit of sel is high.
- R4: While hold is high, a rising clk edge leaves sel and carry unchanged.
- R5: carry is 1 in states 0 through 4 and 0 in states 5 through 9. It therefore rises only on the step from state 9 to state 0.
- R6: clr overrides hold and clk. While clr stays high, clock edges do not move the counter away from state 0, whatever the level of hold.
- R7: The register walks 0 to 9 through the codes 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000 and 10000, with bit 0 on the right. From any other five-bit pattern, the next counted edge puts the counter in state 0. From a legal code, the next counted edge moves it to the following state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; counts on the rising edge |
| clr | input | 1 | Asynchronous clear to state 0, active high |
| hold | input | 1 | Count inhibit, active high |
| sel | output | 10 | One-hot decoded state; sel[k] is high in state k |
| carry | output | 1 | Divide-by-ten output, high in states 0 to 4 |

## Verification
The bench loads each of the 32 register patterns in turn and checks where the next counted edge takes the counter. A design that kept stray patterns would either hold them or fall into a second ring that never shows a clean one-hot output. Clear is raised between clock edges and checked before the next edge arrives, which catches a clear that waits for the clock. Clear is also held across edges with hold low, which catches a design that lets counting win over clear. Long runs over the wrap from 9 to 0 would expose a carry taken from the wrong stage or with the wrong polarity, since its phase would be wrong against the decoded lines. Hold is held high over many edges in several states, which catches a hold input that still moves the counter.

// File: rtl/johnson_decade.sv
module johnson_decade (
  input  logic       clk,
  input  logic       clr,
  input  logic       hold,
  output logic [9:0] sel,
  output logic       carry
);
  logic [4:0] q;
  logic       legal;

  assign legal = $countones(q[4:1] ^ q[3:0]) <= 1;

  always_ff @(posedge clk or posedge clr)
    if (clr)        q <= '0;
    else if (!hold) q <= legal ? {q[3:0], ~q[4]} : '0;

  assign sel[0] = ~q[4] & ~q[0];
  assign sel[5] =  q[4] &  q[0];

  genvar i;
  generate
    for (i = 1; i < 5; i++) begin : g_dec
      assign sel[i]   =  q[i-1] & ~q[i];
      assign sel[i+5] = ~q[i-1] &  q[i];
    end
  endgenerate

  assign carry = ~q[4];
endmodule

module johnson_decade_chk (
  input logic       clk,
  input logic       clr,
  input logic       hold,
  input logic [9:0] sel,
  input logic       carry
);
  // R1
  clear_state_chk: assert property (@(posedge clk) clr |-> (sel == 10'd1 && carry));

  // R3
  one_hot_chk: assert property (@(posedge clk) disable iff (clr)
    !hold |=> $countones(sel) == 1);

  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (clr)
    hold |=> ($stable(sel) && $stable(carry)));

  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (clr)
    (!hold && sel[9]) |=> sel[0]);

  // R5
  carry_phase_chk: assert property (@(posedge clk) disable iff (clr)
    !hold |=> carry == |sel[4:0]);

  // R5
  carry_rise_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(carry) |-> sel[0]);
endmodule

bind johnson_decade johnson_decade_chk u_chk (
  .clk(clk), .clr(clr), .hold(hold), .sel(sel), .carry(carry)
);

// File: tb/johnson_decade_bench.sv
module johnson_decade_bench;
  logic       clk = 0;
  logic       clr = 1;
  logic       hold = 0;
  logic [9:0] sel;
  logic       carry;
  int checks = 0;
  int errors = 0;
  int st = 0;

  always #5 clk = ~clk;

  johnson_decade u_johnson_decade (
    .clk(clk), .clr(clr), .hold(hold), .sel(sel), .carry(carry)
  );

  function automatic logic [4:0] code_of(int k);
    if (k <= 5) return 5'((32'd1 << k) - 1);
    return 5'((32'h1f << (k - 5)) & 32'h1f);
  endfunction

  task automatic expect_state(int k, string req);
    logic [9:0] es;
    logic ec;
    es = 10'(32'd1 << k);
    ec = (k < 5);
    checks++;
    if (sel !== es || carry !== ec) begin
      errors++;
      $display("FAIL %s: sel=%b carry=%b expected sel=%b carry=%b", req, sel, carry, es, ec);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    expect_state(0, "R1 reset state");
    clr = 0;
    st = 0;
    // R2 R5: count through several wraps
    for (int n = 0; n < 35; n++) begin
      tick();
      st = (st + 1) % 10;
      expect_state(st, "R2/R5 count");
    end
    // R4: hold in a few states
    for (int r = 0; r < 4; r++) begin
      hold = 1;
      repeat (3 + r) tick();
      expect_state(st, "R4 hold");
      hold = 0;
      repeat (r + 2) begin
        tick();
        st = (st + 1) % 10;
      end
      expect_state(st, "R2 resume after hold");
    end
    // R1: asynchronous clear between edges
    while (st != 7) begin tick(); st = (st + 1) % 10; end
    #1 clr = 1;
    #1 expect_state(0, "R1 async clear");
    // R6: clear wins over clock and hold
    hold = 0;
    repeat (3) tick();
    expect_state(0, "R6 clear over clock");
    hold = 1;
    repeat (2) tick();
    expect_state(0, "R6 clear over hold");
    hold = 0;
    clr = 0;
    tick();
    expect_state(1, "R2 first count after clear");
    // R7: every five-bit pattern
    for (int p = 0; p < 32; p++) begin
      int nxt;
      nxt = 0;
      for (int k = 0; k < 10; k++)
        if (code_of(k) == 5'(p)) nxt = (k + 1) % 10;
      @(negedge clk);
      clr = 1;
      hold = 0;
      @(posedge clk);
      @(negedge clk);
      force u_johnson_decade.q = 5'(p);
      release u_johnson_decade.q;
      clr = 0;
      tick();
      expect_state(nxt, "R7 pattern recovery");
      tick();
      expect_state((nxt + 1) % 10, "R3 one-hot after recovery");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule